// File: doc/BRIEF.md
# BCD Calendar Real-Time Clock with Full-Match Alarm

The block is a calendar clock that counts seconds, minutes, hours, day of month, month, two-digit year (2000 to 2099) and a weekday. Every value is held as a packed BCD byte. A single enable input that pulses at 32768 Hz is divided down inside the block to make one calendar update per second. The update applies the real calendar: month lengths, February with 28 or 29 days, and the wrap of the century.

Software reaches the clock through a byte-wide register bus with address, write strobe, read strobe and data. Through it, software loads any calendar field, sets an alarm time, starts and stops counting, and reads a status byte. The alarm fires only when all six date and time fields equal the programmed alarm exactly, because no field can be skipped. The status byte carries event flags for the second, minute, hour and day, the alarm and the power-up. A busy bit is high during the final tick before each update, so software can place its accesses in the quiet window that follows. Two interrupt outputs report the per-second event and the alarm, each behind its own enable bit.

Top module: `bcd_rtc_top`

## Requirements
- R1: After reset the clock reads 2000-01-01 00:00:00 with weekday 0. Control reads 0x00 (stopped), status reads 0x80 (power-up flag only), the interrupt register reads 0x00, and any unmapped or misaligned address reads 0x00. Register word addresses: 0x00 sec, 0x04 min, 0x08 hour, 0x0C day, 0x10 month, 0x14 year, 0x18 weekday; the alarm uses 0x20..0x34 in the same field order; 0x40 control, 0x44 status, 0x48 interrupt enable.
- R2: The one-second update happens once per TICKS_PER_SEC enable pulses, and only while control bit 0 is 1. With that bit at 0, both the tick count and the calendar hold their values.
- R3: Seconds and minutes wrap from 59 to 00 and carry. Hours wrap from 23 to 00 and carry. The weekday steps from 0 to 6 on each day change and then returns to 0.
- R4: The day wraps to 01 after the last day of the current month: 30 for months 04, 06, 09 and 11, 31 for the other months, and in February 29 when the binary value of the year modulo 4 is 0, otherwise 28. The month wraps from 12 to 01 and the year from 99 to 00.
- R5: A bus write to a time register loads that BCD byte directly and reads back unchanged. In a cycle that carries such a write, the calendar skips that cycle's update.
- R6: Status bit 6 (alarm) sets in the cycle after an update only if seconds, minutes, hours, day, month and year all equal the six alarm registers. A difference in any one field keeps the flag clear.
- R7: Writing 1 to status bits 7 (power-up), 6 (alarm), 5 (day), 4 (hour), 3 (minute) or 2 (second) clears that bit. Writing 0 leaves the bit unchanged. A set event in the same cycle as a clear wins.
- R8: Status bit 2 sets on every applied one-second update and also clears when the status register is read.
- R9: Status bit 0 (busy) is 1 while the clock runs and the tick count sits in the last tick of the second. Status bit 1 (run) mirrors control bit 0.
- R10: In the interrupt register (0x48), bit 3 enables the alarm interrupt and bit 2 enables the timer interrupt; its other bits read 0. irq_timer equals status bit 2 AND the timer enable, and irq_alarm equals status bit 6 AND the alarm enable.
- R11: Status bits 3, 4 and 5 set when an update rolls the minute, the hour and the day over, respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counting clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | One-cycle pulse at the 32768 Hz rate |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (a status read clears the second flag) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| irq_timer | output | 1 | Per-second interrupt |
| irq_alarm | output | 1 | Alarm interrupt |

## Verification
The calendar is started from preset dates chosen to hit each kind of carry: a minute-hour-day chain at the end of a non-leap February, a leap February stepping onto the 29th and then into March, a 30-day month, and the last second of 2099. Between them these separate a wrong month-length table, a wrong leap rule and a wrong century wrap. The alarm is tried once with every field equal and once with only the year different, which tells a true full-field match from a partial one. Stopped intervals, repeated status reads around the busy window, zero-writes against write-one-to-clear flags, and a field write while the clock runs each expose a different ordering between a bus access and the update.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

   localparam int NUM_FIELDS = 6;

   typedef struct packed {
      logic [7:0] year;
      logic [7:0] mon;
      logic [7:0] day;
      logic [7:0] hour;
      logic [7:0] min;
      logic [7:0] sec;
   } caltime_t;

   // BCD increment of a two-digit byte (no wrap handling)
   function automatic logic [7:0] bcd_inc(input logic [7:0] v);
      if (v[3:0] == 4'h9) return {v[7:4] + 4'h1, 4'h0};
      else                return {v[7:4], v[3:0] + 4'h1};
   endfunction

   function automatic logic is_leap(input logic [7:0] yr);
      logic [6:0] b;
      b = 7'(yr[7:4]) * 7'd10 + 7'(yr[3:0]);
      return (b[1:0] == 2'b00);
   endfunction

   // last day of month, BCD
   function automatic logic [7:0] month_len(input logic [7:0] mon, input logic [7:0] yr);
      case (mon)
         8'h02:                     return is_leap(yr) ? 8'h29 : 8'h28;
         8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
         default:                   return 8'h31;
      endcase
   endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
   parameter int TICKS_PER_SEC = 32768
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic tick_en,
   output logic busy,
   output logic sec_pulse
);
   localparam int CNT_W = (TICKS_PER_SEC > 2) ? $clog2(TICKS_PER_SEC) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(TICKS_PER_SEC - 1);
   localparam bit IS_POW2 = ((TICKS_PER_SEC & (TICKS_PER_SEC - 1)) == 0);

   initial assert (TICKS_PER_SEC >= 2) else $error("TICKS_PER_SEC must be at least 2");

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] cnt_nxt;

   generate
      if (IS_POW2) begin : g_wrap_free
         assign cnt_nxt = cnt + CNT_W'(1);
      end else begin : g_wrap_cmp
         assign cnt_nxt = (cnt == LAST) ? '0 : cnt + CNT_W'(1);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)              cnt <= '0;
      else if (run && tick_en) cnt <= cnt_nxt;
   end

   assign busy      = run && (cnt == LAST);
   assign sec_pulse = busy && tick_en;

   AST_PRE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> $stable(cnt)); // R2
   AST_BUSY_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
      sec_pulse |=> !busy); // R9
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
   import rtc_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       upd,
   input  logic       wr_en,
   input  logic [2:0] wr_field,
   input  logic [7:0] wr_data,
   output caltime_t   now,
   output logic [7:0] wday,
   output logic       ev_min,
   output logic       ev_hour,
   output logic       ev_day
);
   logic step, sec_end, min_end, hr_end, day_end, mon_end, yr_end;

   assign step    = upd && !wr_en;
   assign sec_end = (now.sec  == 8'h59);
   assign min_end = (now.min  == 8'h59);
   assign hr_end  = (now.hour == 8'h23);
   assign day_end = (now.day  == month_len(now.mon, now.year));
   assign mon_end = (now.mon  == 8'h12);
   assign yr_end  = (now.year == 8'h99);

   assign ev_min  = step && sec_end;
   assign ev_hour = ev_min && min_end;
   assign ev_day  = ev_hour && hr_end;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         now  <= '{year: 8'h00, mon: 8'h01, day: 8'h01, hour: 8'h00, min: 8'h00, sec: 8'h00};
         wday <= 8'h00;
      end else if (wr_en) begin
         case (wr_field)
            3'd0: now.sec  <= wr_data;
            3'd1: now.min  <= wr_data;
            3'd2: now.hour <= wr_data;
            3'd3: now.day  <= wr_data;
            3'd4: now.mon  <= wr_data;
            3'd5: now.year <= wr_data;
            3'd6: wday     <= wr_data;
            default: ;
         endcase
      end else if (upd) begin
         now.sec <= sec_end ? 8'h00 : bcd_inc(now.sec);
         if (ev_min)  now.min  <= min_end ? 8'h00 : bcd_inc(now.min);
         if (ev_hour) now.hour <= hr_end ? 8'h00 : bcd_inc(now.hour);
         if (ev_day) begin
            now.day <= day_end ? 8'h01 : bcd_inc(now.day);
            wday    <= (wday == 8'h06) ? 8'h00 : wday + 8'h01;
         end
         if (ev_day && day_end)            now.mon  <= mon_end ? 8'h01 : bcd_inc(now.mon);
         if (ev_day && day_end && mon_end) now.year <= yr_end ? 8'h00 : bcd_inc(now.year);
      end
   end

   AST_CAL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!upd && !wr_en) |=> ($stable(now) && $stable(wday))); // R2
   AST_SEC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (upd && !wr_en && now.sec == 8'h59) |=> (now.sec == 8'h00)); // R3
   AST_CENTURY_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (upd && !wr_en && now.year == 8'h99 && now.mon == 8'h12 && now.day == 8'h31 &&
       now.hour == 8'h23 && now.min == 8'h59 && now.sec == 8'h59)
      |=> (now.year == 8'h00 && now.mon == 8'h01 && now.day == 8'h01)); // R4
   AST_SEC_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_field == 3'd0) |=> (now.sec == $past(wr_data))); // R5
endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
   import rtc_pkg::*;
(
   input  caltime_t now,
   input  caltime_t target,
   output logic     match
);
   localparam int TW = $bits(caltime_t);

   initial assert (TW == NUM_FIELDS * 8) else $error("field layout does not match NUM_FIELDS");

   logic [TW-1:0]         nv, tv;
   logic [NUM_FIELDS-1:0] eq;

   assign nv = now;
   assign tv = target;

   generate
      for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
         assign eq[i] = (nv[8*i +: 8] == tv[8*i +: 8]);
      end
   endgenerate

   assign match = &eq;
endmodule

// File: rtl/bcd_rtc_top.sv
module bcd_rtc_top
   import rtc_pkg::*;
#(
   parameter int TICKS_PER_SEC = 32768,
   parameter int ADDR_W        = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   output logic              irq_timer,
   output logic              irq_alarm
);
   localparam int WIX_W = ADDR_W - 2;
   localparam logic [WIX_W-1:0] W_WDAY  = WIX_W'(6);
   localparam logic [WIX_W-1:0] W_ASEC  = WIX_W'(8);
   localparam logic [WIX_W-1:0] W_AYEAR = WIX_W'(13);
   localparam logic [WIX_W-1:0] W_CTRL  = WIX_W'(16);
   localparam logic [WIX_W-1:0] W_STAT  = WIX_W'(17);
   localparam logic [WIX_W-1:0] W_INTE  = WIX_W'(18);

   initial assert (ADDR_W >= 7) else $error("ADDR_W must reach the interrupt register");

   logic [WIX_W-1:0] wix;
   logic             aligned;
   logic             wr_time, wr_alarm, wr_ctrl, wr_stat, wr_inte, rd_stat;
   logic [2:0]       alarm_field;

   assign wix         = bus_addr[ADDR_W-1:2];
   assign aligned     = (bus_addr[1:0] == 2'b00);
   assign wr_time     = bus_wr && aligned && (wix <= W_WDAY);
   assign wr_alarm    = bus_wr && aligned && (wix >= W_ASEC) && (wix <= W_AYEAR);
   assign wr_ctrl     = bus_wr && aligned && (wix == W_CTRL);
   assign wr_stat     = bus_wr && aligned && (wix == W_STAT);
   assign wr_inte     = bus_wr && aligned && (wix == W_INTE);
   assign rd_stat     = bus_rd && aligned && (wix == W_STAT);
   assign alarm_field = 3'(wix - W_ASEC);

   logic [7:0] ctrl;
   caltime_t   alarm;
   logic       en_alarm, en_timer;
   logic       f_sec, f_min, f_hour, f_day, f_alarm, f_pu;
   logic       upd_d;

   logic       busy, sec_pulse, cal_step, match;
   caltime_t   now;
   logic [7:0] wday;
   logic       ev_min, ev_hour, ev_day;

   rtc_prescaler #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_pre (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (ctrl[0]),
      .tick_en   (tick_en),
      .busy      (busy),
      .sec_pulse (sec_pulse)
   );

   rtc_calendar u_cal (
      .clk      (clk),
      .rst_n    (rst_n),
      .upd      (sec_pulse),
      .wr_en    (wr_time),
      .wr_field (wix[2:0]),
      .wr_data  (bus_wdata),
      .now      (now),
      .wday     (wday),
      .ev_min   (ev_min),
      .ev_hour  (ev_hour),
      .ev_day   (ev_day)
   );

   rtc_alarm_match u_match (
      .now    (now),
      .target (alarm),
      .match  (match)
   );

   assign cal_step = sec_pulse && !wr_time;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl     <= 8'h00;
         alarm    <= '{year: 8'h00, mon: 8'h01, day: 8'h01, hour: 8'h00, min: 8'h00, sec: 8'h00};
         en_alarm <= 1'b0;
         en_timer <= 1'b0;
      end else begin
         if (wr_ctrl) ctrl <= bus_wdata;
         if (wr_inte) begin
            en_alarm <= bus_wdata[3];
            en_timer <= bus_wdata[2];
         end
         if (wr_alarm) begin
            case (alarm_field)
               3'd0: alarm.sec  <= bus_wdata;
               3'd1: alarm.min  <= bus_wdata;
               3'd2: alarm.hour <= bus_wdata;
               3'd3: alarm.day  <= bus_wdata;
               3'd4: alarm.mon  <= bus_wdata;
               3'd5: alarm.year <= bus_wdata;
               default: ;
            endcase
         end
      end
   end

   // event flags: a set in the same cycle beats a clear
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         f_sec   <= 1'b0;
         f_min   <= 1'b0;
         f_hour  <= 1'b0;
         f_day   <= 1'b0;
         f_alarm <= 1'b0;
         f_pu    <= 1'b1;
         upd_d   <= 1'b0;
      end else begin
         upd_d <= cal_step;
         if (cal_step)                                 f_sec <= 1'b1;
         else if (rd_stat || (wr_stat && bus_wdata[2])) f_sec <= 1'b0;
         if (ev_min)                        f_min <= 1'b1;
         else if (wr_stat && bus_wdata[3])  f_min <= 1'b0;
         if (ev_hour)                       f_hour <= 1'b1;
         else if (wr_stat && bus_wdata[4])  f_hour <= 1'b0;
         if (ev_day)                        f_day <= 1'b1;
         else if (wr_stat && bus_wdata[5])  f_day <= 1'b0;
         if (upd_d && match)                f_alarm <= 1'b1;
         else if (wr_stat && bus_wdata[6])  f_alarm <= 1'b0;
         if (wr_stat && bus_wdata[7])       f_pu <= 1'b0;
      end
   end

   logic [7:0] status;
   assign status = {f_pu, f_alarm, f_day, f_hour, f_min, f_sec, ctrl[0], busy};

   always_comb begin
      bus_rdata = 8'h00;
      if (aligned) begin
         case (wix)
            WIX_W'(0):  bus_rdata = now.sec;
            WIX_W'(1):  bus_rdata = now.min;
            WIX_W'(2):  bus_rdata = now.hour;
            WIX_W'(3):  bus_rdata = now.day;
            WIX_W'(4):  bus_rdata = now.mon;
            WIX_W'(5):  bus_rdata = now.year;
            WIX_W'(6):  bus_rdata = wday;
            WIX_W'(8):  bus_rdata = alarm.sec;
            WIX_W'(9):  bus_rdata = alarm.min;
            WIX_W'(10): bus_rdata = alarm.hour;
            WIX_W'(11): bus_rdata = alarm.day;
            WIX_W'(12): bus_rdata = alarm.mon;
            WIX_W'(13): bus_rdata = alarm.year;
            W_CTRL:     bus_rdata = ctrl;
            W_STAT:     bus_rdata = status;
            W_INTE:     bus_rdata = {4'b0000, en_alarm, en_timer, 2'b00};
            default:    bus_rdata = 8'h00;
         endcase
      end
   end

   assign irq_timer = f_sec && en_timer;
   assign irq_alarm = f_alarm && en_alarm;

   AST_ALARM_AFTER_UPD: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(f_alarm) |-> $past(upd_d)); // R6
   AST_SECFLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
      cal_step |=> f_sec); // R8
   AST_PU_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      !$rose(f_pu)); // R7
   AST_SKIP_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (sec_pulse && wr_time) |=> !upd_d); // R5
endmodule

// File: tb/sim_bcd_rtc_top.sv
module sim_bcd_rtc_top;
   localparam int T = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_en = 1'b0;
   logic [7:0] bus_addr = 8'h00;
   logic       bus_wr = 1'b0;
   logic       bus_rd = 1'b0;
   logic [7:0] bus_wdata = 8'h00;
   logic [7:0] bus_rdata;
   logic       irq_timer, irq_alarm;

   int n_chk = 0;
   int n_err = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   bcd_rtc_top #(.TICKS_PER_SEC(T), .ADDR_W(8)) u0 (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_addr(bus_addr),
      .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .irq_timer(irq_timer), .irq_alarm(irq_alarm)
   );

   // ---------------- behavioural reference model ----------------
   int m_sec, m_min, m_hour, m_day, m_mon, m_year, m_wday, m_pcnt;
   logic [7:0] m_ctrl;
   logic [7:0] m_al[6];
   bit m_ena, m_ent, m_fs, m_fm, m_fh, m_fd, m_fa, m_fpu, m_upd_d;

   function automatic logic [7:0] bcd(input int v);
      return 8'(((v / 10) << 4) | (v % 10));
   endfunction
   function automatic int bin(input logic [7:0] b);
      return int'(b[7:4]) * 10 + int'(b[3:0]);
   endfunction
   function automatic int mdays(input int m, input int y);
      if (m == 2) return (y % 4 == 0) ? 29 : 28;
      if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
      return 31;
   endfunction

   function automatic logic [7:0] m_read(input logic [7:0] a);
      logic busy;
      busy = m_ctrl[0] && (m_pcnt == T - 1);
      case (a)
         8'h00: return bcd(m_sec);
         8'h04: return bcd(m_min);
         8'h08: return bcd(m_hour);
         8'h0C: return bcd(m_day);
         8'h10: return bcd(m_mon);
         8'h14: return bcd(m_year);
         8'h18: return bcd(m_wday);
         8'h20: return m_al[0];
         8'h24: return m_al[1];
         8'h28: return m_al[2];
         8'h2C: return m_al[3];
         8'h30: return m_al[4];
         8'h34: return m_al[5];
         8'h40: return m_ctrl;
         8'h44: return {m_fpu, m_fa, m_fd, m_fh, m_fm, m_fs, m_ctrl[0], busy};
         8'h48: return {4'b0000, m_ena, m_ent, 2'b00};
         default: return 8'h00;
      endcase
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_sec = 0; m_min = 0; m_hour = 0; m_day = 1; m_mon = 1; m_year = 0; m_wday = 0;
         m_pcnt = 0; m_ctrl = 8'h00; m_ena = 0; m_ent = 0;
         m_al[0] = 8'h00; m_al[1] = 8'h00; m_al[2] = 8'h00;
         m_al[3] = 8'h01; m_al[4] = 8'h01; m_al[5] = 8'h00;
         m_fs = 0; m_fm = 0; m_fh = 0; m_fd = 0; m_fa = 0; m_fpu = 1; m_upd_d = 0;
      end else begin
         bit spulse, wtime, step, match, evm, evh, evd, ws, rs;
         spulse = m_ctrl[0] && (m_pcnt == T - 1) && tick_en;
         wtime  = bus_wr && bus_addr <= 8'h18 && bus_addr[1:0] == 2'b00;
         step   = spulse && !wtime;
         match  = bcd(m_sec) == m_al[0] && bcd(m_min) == m_al[1] && bcd(m_hour) == m_al[2] &&
                  bcd(m_day) == m_al[3] && bcd(m_mon) == m_al[4] && bcd(m_year) == m_al[5];
         evm = step && m_sec == 59;
         evh = evm && m_min == 59;
         evd = evh && m_hour == 23;
         ws  = bus_wr && bus_addr == 8'h44;
         rs  = bus_rd && bus_addr == 8'h44;
         // flags (set wins over clear)
         if (step) m_fs = 1; else if (rs || (ws && bus_wdata[2])) m_fs = 0;
         if (evm) m_fm = 1; else if (ws && bus_wdata[3]) m_fm = 0;
         if (evh) m_fh = 1; else if (ws && bus_wdata[4]) m_fh = 0;
         if (evd) m_fd = 1; else if (ws && bus_wdata[5]) m_fd = 0;
         if (m_upd_d && match) m_fa = 1; else if (ws && bus_wdata[6]) m_fa = 0;
         if (ws && bus_wdata[7]) m_fpu = 0;
         m_upd_d = step;
         if (m_ctrl[0] && tick_en) m_pcnt = (m_pcnt + 1) % T;
         if (wtime) begin
            case (bus_addr)
               8'h00: m_sec  = bin(bus_wdata);
               8'h04: m_min  = bin(bus_wdata);
               8'h08: m_hour = bin(bus_wdata);
               8'h0C: m_day  = bin(bus_wdata);
               8'h10: m_mon  = bin(bus_wdata);
               8'h14: m_year = bin(bus_wdata);
               default: m_wday = bin(bus_wdata);
            endcase
         end else if (step) begin
            m_sec++;
            if (m_sec == 60) begin m_sec = 0; m_min++; end
            if (m_min == 60) begin m_min = 0; m_hour++; end
            if (m_hour == 24) begin
               m_hour = 0; m_day++; m_wday = (m_wday + 1) % 7;
               if (m_day > mdays(m_mon, m_year)) begin m_day = 1; m_mon++; end
               if (m_mon == 13) begin m_mon = 1; m_year = (m_year + 1) % 100; end
            end
         end
         if (bus_wr && bus_addr == 8'h40) m_ctrl = bus_wdata;
         if (bus_wr && bus_addr == 8'h48) begin m_ena = bus_wdata[3]; m_ent = bus_wdata[2]; end
         if (bus_wr && bus_addr >= 8'h20 && bus_addr <= 8'h34 && bus_addr[1:0] == 2'b00)
            m_al[(bus_addr - 8'h20) >> 2] = bus_wdata;
      end
   end

   // ---------------- checking ----------------
   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%02h expected=%02h at %0t", tag, act, exp, $time);
      end
   endtask

   // interrupt outputs compared every cycle (R10)
   initial begin
      forever begin
         @(negedge clk);
         #1;
         if (rst_n) begin
            chk("R10 irq_timer", {7'd0, irq_timer}, {7'd0, m_fs && m_ent});
            chk("R10 irq_alarm", {7'd0, irq_alarm}, {7'd0, m_fa && m_ena});
         end
      end
   end

   // tick enable: every second clock
   initial begin
      forever begin
         @(negedge clk);
         tick_en = ~tick_en;
      end
   end

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, input string tag);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      #1;
      chk(tag, bus_rdata, m_read(a));
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic set_time(input logic [7:0] y, input logic [7:0] mo, input logic [7:0] d,
                           input logic [7:0] h, input logic [7:0] mi, input logic [7:0] s);
      wr(8'h14, y); wr(8'h10, mo); wr(8'h0C, d); wr(8'h08, h); wr(8'h04, mi); wr(8'h00, s);
   endtask

   task automatic read_date(input string tag);
      rd(8'h00, tag); rd(8'h04, tag); rd(8'h08, tag);
      rd(8'h0C, tag); rd(8'h10, tag); rd(8'h14, tag);
   endtask

   localparam int SEC_CYC = 2 * T;

   initial begin
      idle(4);
      rst_n = 1'b1;
      // R1: reset state and map
      rd(8'h44, "R1 status"); rd(8'h40, "R1 ctrl"); rd(8'h48, "R1 inte");
      read_date("R1 time"); rd(8'h18, "R1 wday");
      rd(8'h1C, "R1 unmapped"); rd(8'h4C, "R1 unmapped"); rd(8'h01, "R1 misaligned");
      // R7: zero write keeps power-up, one clears it
      wr(8'h44, 8'h00); rd(8'h44, "R7 zero write");
      wr(8'h44, 8'h80); rd(8'h44, "R7 w1c pu");
      // R5: load fields while stopped
      set_time(8'h23, 8'h02, 8'h28, 8'h23, 8'h59, 8'h58);
      wr(8'h18, 8'h06);
      read_date("R5 load"); rd(8'h18, "R5 wday");
      // R2: stopped clock holds
      idle(5 * SEC_CYC); rd(8'h00, "R2 stopped"); rd(8'h44, "R9 run low");
      // R3/R4/R11: non-leap Feb end, weekday wrap
      wr(8'h48, 8'h04); wr(8'h40, 8'h01);
      idle(2 * SEC_CYC + 2);
      read_date("R4 feb28 nonleap"); rd(8'h18, "R3 wday wrap");
      rd(8'h44, "R11 events"); rd(8'h44, "R8 read clears");
      wr(8'h44, 8'h00); rd(8'h44, "R7 zero write events");
      wr(8'h44, 8'h38); rd(8'h44, "R7 w1c events");
      // R9: poll status across the busy window
      for (int i = 0; i < 3 * SEC_CYC; i++) rd(8'h44, "R9 busy poll");
      // R4: leap February
      wr(8'h40, 8'h00);
      set_time(8'h24, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59);
      wr(8'h40, 8'h01); idle(SEC_CYC + 2); wr(8'h40, 8'h00);
      read_date("R4 leap feb29");
      wr(8'h08, 8'h23); wr(8'h04, 8'h59); wr(8'h00, 8'h59);
      wr(8'h40, 8'h01); idle(SEC_CYC + 2); wr(8'h40, 8'h00);
      read_date("R4 leap to march");
      // R4: 30-day month
      set_time(8'h31, 8'h04, 8'h30, 8'h23, 8'h59, 8'h59);
      wr(8'h40, 8'h01); idle(SEC_CYC + 2); wr(8'h40, 8'h00);
      read_date("R4 april end");
      // R4: century wrap
      set_time(8'h99, 8'h12, 8'h31, 8'h23, 8'h59, 8'h59);
      wr(8'h40, 8'h01); idle(SEC_CYC + 2); wr(8'h40, 8'h00);
      read_date("R4 year wrap"); rd(8'h44, "R11 day event");
      // R6: full match fires
      set_time(8'h31, 8'h07, 8'h15, 8'h10, 8'h20, 8'h30);
      wr(8'h34, 8'h31); wr(8'h30, 8'h07); wr(8'h2C, 8'h15);
      wr(8'h28, 8'h10); wr(8'h24, 8'h20); wr(8'h20, 8'h32);
      rd(8'h20, "R6 alarm readback"); rd(8'h34, "R6 alarm readback");
      wr(8'h44, 8'hFC);
      wr(8'h48, 8'h0C); rd(8'h48, "R10 inte");
      wr(8'h40, 8'h01); idle(3 * SEC_CYC + 2); wr(8'h40, 8'h00);
      rd(8'h44, "R6 match"); 
      wr(8'h44, 8'h40); rd(8'h44, "R7 w1c alarm");
      // R6: one field differs (year)
      set_time(8'h31, 8'h07, 8'h15, 8'h10, 8'h20, 8'h30);
      wr(8'h34, 8'h32);
      wr(8'h40, 8'h01); idle(3 * SEC_CYC + 2); wr(8'h40, 8'h00);
      rd(8'h44, "R6 year differs");
      // R5: write while running (update may coincide)
      wr(8'h40, 8'h01);
      for (int i = 0; i < SEC_CYC; i++) begin
         wr(8'h00, 8'h59);
         rd(8'h00, "R5 write while running"); rd(8'h04, "R5 write while running");
      end
      wr(8'hFF, 8'h5A); rd(8'h48, "R10 other bits zero");
      wr(8'h48, 8'hFF); rd(8'h48, "R10 other bits zero");
      idle(2 * SEC_CYC);
      rd(8'h44, "R8 second flag");
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end
endmodule